// File: doc/BRIEF.md
# Bidirectional Reversible Register-Update ALU

This unit computes the next value of a destination register for a 16-bit register machine that can execute either forward or backward. For each accepted operation it takes an operation code, a direction flag, the current destination value, a 16-bit source operand, an 8-bit immediate and the value on top of an undo stack. One clock later it presents the new destination value with a write enable, together with a push or pop request for that undo stack.

Operations fall into two classes. Bit 3 of the operation code selects the class, and the class decides how undo works. Invertible operations (the two immediate XORs, register XOR, add, subtract, rotate-left) are undone by arithmetic: add and subtract trade places, rotate-left becomes rotate-right, and the XOR forms are their own inverse. These operations never touch the undo stack. Lossy operations (the two immediate loads, arithmetic shift right, OR, AND, duplicate) save the old destination value on the stack when run forward. When run in reverse they restore the destination from the stack top.

The surrounding pipeline fetches the operands, presents the stack top on `undo_top_i`, and acts on the registered requests. Decoding of the instruction word, memory exchange and control flow are handled elsewhere.

Top module: `revalu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following cycle shows `valid_o`, `wr_en_o`, `push_o` and `pop_o` all low.
- R2: Every output request appears exactly one cycle after the edge that samples `valid_i` high. A cycle with `valid_i` low produces no write, push or pop.
- R3: XOR-high (op 0) gives dst ^ (imm << 8), XOR-low (op 1) gives dst ^ imm, and XOR (op 4) gives dst ^ src. All three give the same result in both directions (`rev_i` = 1 is reverse).
- R4: Add (op 2) gives dst + src forward and dst - src in reverse, modulo 2^16. Subtract (op 3) gives dst - src forward and dst + src in reverse.
- R5: Rotate (op 5) rotates dst left by src[3:0] forward and right by src[3:0] in reverse. Bits 15:4 of src are ignored.
- R6: Load-high (op 8) writes imm << 8 with a zero low byte. Load-low (op 9) writes imm sign-extended to 16 bits. Both operations push in the forward direction.
- R7: In the forward direction, shift (op 10) writes dst arithmetically shifted right by src[3:0]. OR (op 11) writes dst | src, AND (op 12) writes dst & src, and duplicate (op 13) writes src. Each of these pushes.
- R8: A push is always accompanied by a write in the same cycle. The pushed data is the destination value as it was before that write.
- R9: In reverse, every lossy operation (ops 8 to 13) writes `undo_top_i` to the destination and requests a pop. It does not push.
- R10: Invertible operations (ops 0 to 5) write in both directions and never push or pop.
- R11: Unassigned codes (6, 7, 14, 15) cause no write, no push and no pop, in either direction.
- R12: Running any defined operation forward and then in reverse, with the forward result as dst (and, for lossy ops, the pushed value as `undo_top_i`), returns the original destination value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code; bit 3 set means lossy class |
| rev_i | input | 1 | 1 = reverse execution |
| dst_i | input | 16 | Current destination register value |
| src_i | input | 16 | Source operand |
| imm_i | input | 8 | Immediate operand |
| undo_top_i | input | 16 | Value on top of the undo stack |
| valid_o | output | 1 | Registered copy of valid_i |
| wr_en_o | output | 1 | Write result_o to the destination |
| result_o | output | 16 | New destination value |
| push_o | output | 1 | Push push_data_o on the undo stack |
| push_data_o | output | 16 | Old destination value to save |
| pop_o | output | 1 | Consume the undo stack top |

## Verification
A forward lossy operation raises the destination write and the stack push in the same cycle. The bench checks that the pushed word is the value before the write and not the new result. To provoke this, it drives back-to-back lossy operations whose source and immediate make the new value differ from the old one in every case. The scoreboard compares `push_data_o` with the driven dst and `result_o` with the computed value for the same item. It also checks that no reverse lossy item raises a push together with its pop.

// File: rtl/revalu_pkg.sv
// Package: shared widths, operation codes and result class for the
// reversible ALU. Assumes a 16-bit datapath and 8-bit immediates.
package revalu_pkg;
    localparam int DW    = 16;
    localparam int IMM_W = 8;
    localparam int OP_W  = 4;
    localparam int SH_W  = $clog2(DW);

    // Bit 3 of the code marks the lossy class; the undo logic decodes it.
    typedef enum logic [OP_W-1:0] {
        OPC_XHI = 4'd0,
        OPC_XLO = 4'd1,
        OPC_ADD = 4'd2,
        OPC_SUB = 4'd3,
        OPC_XOR = 4'd4,
        OPC_ROL = 4'd5,
        OPC_LHI = 4'd8,
        OPC_LLO = 4'd9,
        OPC_SHR = 4'd10,
        OPC_OR  = 4'd11,
        OPC_AND = 4'd12,
        OPC_DUP = 4'd13
    } opc_e;

    typedef enum logic [1:0] {
        SH_ROTL = 2'd0,
        SH_ROTR = 2'd1,
        SH_SRA  = 2'd2
    } shmode_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_INV  = 2'd1,
        SEL_LOSS = 2'd2,
        SEL_UNDO = 2'd3
    } rsel_e;
endpackage

// File: rtl/revalu_barrel.sv
// Module: logarithmic barrel shifter. MODE picks rotate-left, rotate-right
// or arithmetic right shift. Assumes WIDTH is a power of two and that the
// amount is already reduced to log2(WIDTH) bits.
module revalu_barrel
    import revalu_pkg::*;
#(
    parameter int      WIDTH = DW,
    parameter shmode_e MODE  = SH_ROTL
) (
    input  logic [WIDTH-1:0]         data_i,
    input  logic [$clog2(WIDTH)-1:0] amt_i,
    output logic [WIDTH-1:0]         data_o
);
    localparam int STAGES = $clog2(WIDTH);

    logic [WIDTH-1:0] stage_q [STAGES+1];

    assign stage_q[0] = data_i;

    // One stage per amount bit; stage k moves by 2**k positions.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [WIDTH-1:0] moved;
        if (MODE == SH_ROTL) begin : g_rotl
            assign moved = {stage_q[k][WIDTH-1-S:0], stage_q[k][WIDTH-1:WIDTH-S]};
        end else if (MODE == SH_ROTR) begin : g_rotr
            assign moved = {stage_q[k][S-1:0], stage_q[k][WIDTH-1:S]};
        end else begin : g_sra
            assign moved = {{S{stage_q[k][WIDTH-1]}}, stage_q[k][WIDTH-1:S]};
        end
        assign stage_q[k+1] = amt_i[k] ? moved : stage_q[k];
    end

    assign data_o = stage_q[STAGES];
endmodule

// File: rtl/revalu_inv.sv
// Module: invertible operations. Computes the XOR forms, add/subtract and
// rotate in either direction. Assumes only ops 0..5 are routed here; any
// other code yields the unchanged destination.
module revalu_inv
    import revalu_pkg::*;
#(
    parameter int WIDTH = DW,
    parameter int IW    = IMM_W
) (
    input  opc_e             op_i,
    input  logic             rev_i,
    input  logic [WIDTH-1:0] dst_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic [IW-1:0]    imm_i,
    output logic [WIDTH-1:0] res_o
);
    localparam int SW = $clog2(WIDTH);

    logic [WIDTH-1:0] rot_l, rot_r;
    logic [WIDTH-1:0] sum, diff;
    logic [WIDTH-1:0] imm_hi, imm_lo;

    revalu_barrel #(.WIDTH(WIDTH), .MODE(SH_ROTL)) u_rotl (
        .data_i (dst_i),
        .amt_i  (src_i[SW-1:0]),
        .data_o (rot_l)
    );

    revalu_barrel #(.WIDTH(WIDTH), .MODE(SH_ROTR)) u_rotr (
        .data_i (dst_i),
        .amt_i  (src_i[SW-1:0]),
        .data_o (rot_r)
    );

    assign sum    = dst_i + src_i;
    assign diff   = dst_i - src_i;
    assign imm_hi = {imm_i, {(WIDTH-IW){1'b0}}};
    assign imm_lo = {{(WIDTH-IW){1'b0}}, imm_i};

    // Pick the forward operation or its inverse.
    always_comb begin
        unique case (op_i)
            OPC_XHI: res_o = dst_i ^ imm_hi;
            OPC_XLO: res_o = dst_i ^ imm_lo;
            OPC_XOR: res_o = dst_i ^ src_i;
            OPC_ADD: res_o = rev_i ? diff : sum;
            OPC_SUB: res_o = rev_i ? sum  : diff;
            OPC_ROL: res_o = rev_i ? rot_r : rot_l;
            default: res_o = dst_i;
        endcase
    end
endmodule

// File: rtl/revalu_loss.sv
// Module: forward value of the lossy operations (loads, arithmetic shift,
// OR, AND, duplicate). Assumes the caller saves the old destination; the
// reverse path does not pass through here.
module revalu_loss
    import revalu_pkg::*;
#(
    parameter int WIDTH = DW,
    parameter int IW    = IMM_W
) (
    input  opc_e             op_i,
    input  logic [WIDTH-1:0] dst_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic [IW-1:0]    imm_i,
    output logic [WIDTH-1:0] res_o
);
    localparam int SW = $clog2(WIDTH);

    logic [WIDTH-1:0] shr_v;

    revalu_barrel #(.WIDTH(WIDTH), .MODE(SH_SRA)) u_sra (
        .data_i (dst_i),
        .amt_i  (src_i[SW-1:0]),
        .data_o (shr_v)
    );

    // Select the overwriting result for each lossy code.
    always_comb begin
        unique case (op_i)
            OPC_LHI: res_o = {imm_i, {(WIDTH-IW){1'b0}}};
            OPC_LLO: res_o = {{(WIDTH-IW){imm_i[IW-1]}}, imm_i};
            OPC_SHR: res_o = shr_v;
            OPC_OR:  res_o = dst_i | src_i;
            OPC_AND: res_o = dst_i & src_i;
            OPC_DUP: res_o = src_i;
            default: res_o = dst_i;
        endcase
    end
endmodule

// File: rtl/revalu_undo_ctl.sv
// Module: classifies the operation code and decides write, push, pop and
// the result source. Assumes bit 3 of the code separates the classes and
// that codes 6, 7, 14, 15 are unassigned.
module revalu_undo_ctl
    import revalu_pkg::*;
#(
    parameter int OW = OP_W
) (
    input  logic [OW-1:0] op_i,
    input  logic          rev_i,
    output logic          we_o,
    output logic          push_o,
    output logic          pop_o,
    output rsel_e         sel_o
);
    logic known;
    logic lossy;

    assign lossy = op_i[OW-1];

    // Known codes: low three bits 0..5 within either class.
    always_comb begin
        known = (op_i[OW-2:0] <= 3'd5);
    end

    // Map class and direction onto stack requests and result source.
    always_comb begin
        we_o   = 1'b0;
        push_o = 1'b0;
        pop_o  = 1'b0;
        sel_o  = SEL_NONE;
        if (known) begin
            we_o = 1'b1;
            if (!lossy) begin
                sel_o = SEL_INV;
            end else if (rev_i) begin
                pop_o = 1'b1;
                sel_o = SEL_UNDO;
            end else begin
                push_o = 1'b1;
                sel_o  = SEL_LOSS;
            end
        end
    end
endmodule

// File: rtl/revalu_core.sv
// Module: top of the reversible register-update ALU. Registers the new
// destination value and the undo stack requests one cycle after an
// accepted operation. Assumes undo_top_i holds the stack top in the cycle
// of a reverse lossy operation.
module revalu_core
    import revalu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic             rev_i,
    input  logic [DW-1:0]    dst_i,
    input  logic [DW-1:0]    src_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [DW-1:0]    undo_top_i,
    output logic             valid_o,
    output logic             wr_en_o,
    output logic [DW-1:0]    result_o,
    output logic             push_o,
    output logic [DW-1:0]    push_data_o,
    output logic             pop_o
);
    opc_e          opc;
    logic [DW-1:0] inv_res, loss_res, next_res;
    logic          we_c, push_c, pop_c;
    rsel_e         sel;

    assign opc = opc_e'(op_i);

    revalu_inv #(.WIDTH(DW), .IW(IMM_W)) u_inv (
        .op_i  (opc),
        .rev_i (rev_i),
        .dst_i (dst_i),
        .src_i (src_i),
        .imm_i (imm_i),
        .res_o (inv_res)
    );

    revalu_loss #(.WIDTH(DW), .IW(IMM_W)) u_loss (
        .op_i  (opc),
        .dst_i (dst_i),
        .src_i (src_i),
        .imm_i (imm_i),
        .res_o (loss_res)
    );

    revalu_undo_ctl #(.OW(OP_W)) u_ctl (
        .op_i   (op_i),
        .rev_i  (rev_i),
        .we_o   (we_c),
        .push_o (push_c),
        .pop_o  (pop_c),
        .sel_o  (sel)
    );

    // Choose the result source named by the control decode.
    always_comb begin
        unique case (sel)
            SEL_INV:  next_res = inv_res;
            SEL_LOSS: next_res = loss_res;
            SEL_UNDO: next_res = undo_top_i;
            default:  next_res = dst_i;
        endcase
    end

    // Output register: requests and values appear one cycle after accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o     <= 1'b0;
            wr_en_o     <= 1'b0;
            push_o      <= 1'b0;
            pop_o       <= 1'b0;
            result_o    <= '0;
            push_data_o <= '0;
        end else begin
            valid_o     <= valid_i;
            wr_en_o     <= valid_i & we_c;
            push_o      <= valid_i & push_c;
            pop_o       <= valid_i & pop_c;
            result_o    <= next_res;
            push_data_o <= dst_i;
        end
    end
endmodule

// File: rtl/revalu_core_chk.sv
// Module: property checker for revalu_core, attached by bind below.
module revalu_core_chk
    import revalu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [OP_W-1:0]  op_i,
    input logic             rev_i,
    input logic [DW-1:0]    dst_i,
    input logic [DW-1:0]    src_i,
    input logic [DW-1:0]    undo_top_i,
    input logic             valid_o,
    input logic             wr_en_o,
    input logic [DW-1:0]    result_o,
    input logic             push_o,
    input logic [DW-1:0]    push_data_o,
    input logic             pop_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !wr_en_o && !push_o && !pop_o));

    // R2
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!wr_en_o && !push_o && !pop_o));

    // R3
    xor_both_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd4) |=> (wr_en_o && result_o == ($past(dst_i) ^ $past(src_i))));

    // R4
    add_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd2 && rev_i) |=> (result_o + $past(src_i) == $past(dst_i)));

    // R8
    push_old_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[3]) |=> (!push_o || (wr_en_o && push_data_o == $past(dst_i))));

    // R9
    pop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && rev_i) |=> (!pop_o || (wr_en_o && !push_o && result_o == $past(undo_top_i))));

    // R10
    inv_no_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i[3]) |=> (!push_o && !pop_o));

    // R11
    undef_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[2:0] > 3'd5) |=> (!wr_en_o && !push_o && !pop_o));
endmodule

bind revalu_core revalu_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .op_i        (op_i),
    .rev_i       (rev_i),
    .dst_i       (dst_i),
    .src_i       (src_i),
    .undo_top_i  (undo_top_i),
    .valid_o     (valid_o),
    .wr_en_o     (wr_en_o),
    .result_o    (result_o),
    .push_o      (push_o),
    .push_data_o (push_data_o),
    .pop_o       (pop_o)
);

// File: tb/revalu_core_bench.sv
module revalu_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic        rev_i = 1'b0;
    logic [15:0] dst_i = '0, src_i = '0, undo_top_i = '0;
    logic [7:0]  imm_i = '0;
    logic        valid_o, wr_en_o, push_o, pop_o;
    logic [15:0] result_o, push_data_o;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        logic        wr;
        logic        push;
        logic        pop;
        logic [15:0] res;
        logic [15:0] pdat;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    always #2 clk = ~clk;

    revalu_core u_revalu_core (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .rev_i(rev_i),
        .dst_i(dst_i), .src_i(src_i), .imm_i(imm_i), .undo_top_i(undo_top_i),
        .valid_o(valid_o), .wr_en_o(wr_en_o), .result_o(result_o),
        .push_o(push_o), .push_data_o(push_data_o), .pop_o(pop_o)
    );

    // Reference model written from the requirement list.
    function automatic exp_t model(input logic [3:0] op, input logic rev,
                                   input logic [15:0] d, input logic [15:0] s,
                                   input logic [7:0] im, input logic [15:0] top,
                                   input string tag);
        exp_t e;
        logic [31:0] dd;
        int n;
        n = int'(s[3:0]);
        dd = {d, d};
        e.tag = tag; e.wr = 1'b1; e.push = 1'b0; e.pop = 1'b0; e.pdat = d; e.res = d;
        if (op >= 4'd8 && op <= 4'd13) begin
            if (rev) begin
                e.pop = 1'b1; e.res = top;
            end else begin
                e.push = 1'b1;
                case (op)
                    4'd8:  e.res = {im, 8'h00};
                    4'd9:  e.res = {{8{im[7]}}, im};
                    4'd10: e.res = 16'($signed(d) >>> n);
                    4'd11: e.res = d | s;
                    4'd12: e.res = d & s;
                    default: e.res = s;
                endcase
            end
        end else begin
            case (op)
                4'd0: e.res = d ^ {im, 8'h00};
                4'd1: e.res = d ^ {8'h00, im};
                4'd2: e.res = rev ? d - s : d + s;
                4'd3: e.res = rev ? d + s : d - s;
                4'd4: e.res = d ^ s;
                4'd5: begin
                    logic [31:0] l, r;
                    l = dd << n;
                    r = dd >> n;
                    e.res = rev ? r[15:0] : l[31:16];
                end
                default: e.wr = 1'b0;
            endcase
        end
        return e;
    endfunction

    // Driver: present one operation and queue its expectation.
    task automatic drive(input logic [3:0] op, input logic rev, input logic [15:0] d,
                         input logic [15:0] s, input logic [7:0] im,
                         input logic [15:0] top, input string tag);
        @(negedge clk);
        valid_i = 1'b1; op_i = op; rev_i = rev; dst_i = d; src_i = s;
        imm_i = im; undo_top_i = top;
        sbq.push_back(model(op, rev, d, s, im, top, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_i = 1'b0;
            dst_i = 16'hFFFF; src_i = 16'hFFFF;
        end
    endtask

    // Forward then reverse with the forward outputs fed back.
    task automatic roundtrip(input logic [3:0] op, input logic [15:0] d,
                             input logic [15:0] s, input logic [7:0] im);
        exp_t f;
        exp_t r;
        f = model(op, 1'b0, d, s, im, 16'h0, "R12");
        drive(op, 1'b0, d, s, im, 16'h0, "R12");
        drive(op, 1'b1, f.res, s, im, d, "R12");
        r = model(op, 1'b1, f.res, s, im, d, "R12");
        compared++;
        if (r.res !== d) begin
            mismatched++;
            $display("FAIL R12 op=%0d model roundtrip actual=%h expected=%h", op, r.res, d);
        end
    endtask

    // Monitor: compare each valid output against the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                if (sbq.size() == 0) begin
                    compared++; mismatched++;
                    $display("FAIL R2 unexpected valid_o actual=1 expected=0");
                end else begin
                    exp_t e;
                    logic bad;
                    e = sbq.pop_front();
                    bad = (wr_en_o !== e.wr) || (push_o !== e.push) || (pop_o !== e.pop)
                          || (e.wr && result_o !== e.res)
                          || (e.push && push_data_o !== e.pdat);
                    compared++;
                    if (bad) begin
                        mismatched++;
                        $display("FAIL %s actual wr=%b push=%b pop=%b res=%h pd=%h expected wr=%b push=%b pop=%b res=%h pd=%h",
                                 e.tag, wr_en_o, push_o, pop_o, result_o, push_data_o,
                                 e.wr, e.push, e.pop, e.res, e.pdat);
                    end
                end
            end else begin
                compared++;
                if (wr_en_o || push_o || pop_o) begin
                    mismatched++;
                    $display("FAIL R2 idle cycle actual wr=%b push=%b pop=%b expected 0/0/0",
                             wr_en_o, push_o, pop_o);
                end
            end
        end
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        compared++;
        if (valid_o || wr_en_o || push_o || pop_o) begin
            mismatched++;
            $display("FAIL R1 reset actual v=%b w=%b p=%b q=%b expected 0", valid_o, wr_en_o, push_o, pop_o);
        end
        rst_n = 1'b1;
        idle(2);
        // R3 XOR forms, both directions
        drive(4'd0, 1'b0, 16'h1234, 16'h0, 8'hA5, 16'h0, "R3");
        drive(4'd0, 1'b1, 16'h1234, 16'h0, 8'hA5, 16'h0, "R3");
        drive(4'd1, 1'b1, 16'hFFFF, 16'h0, 8'h0F, 16'h0, "R3");
        drive(4'd4, 1'b0, 16'hF0F0, 16'h3C3C, 8'h00, 16'h0, "R3");
        drive(4'd4, 1'b1, 16'hF0F0, 16'h3C3C, 8'h00, 16'h0, "R3");
        // R4 add/sub with wrap
        drive(4'd2, 1'b0, 16'hFFFF, 16'h0002, 8'h00, 16'h0, "R4");
        drive(4'd2, 1'b1, 16'h0001, 16'h0002, 8'h00, 16'h0, "R4");
        drive(4'd3, 1'b0, 16'h0000, 16'h0001, 8'h00, 16'h0, "R4");
        drive(4'd3, 1'b1, 16'h8000, 16'h8000, 8'h00, 16'h0, "R4");
        // R5 rotate, upper src bits ignored, zero and max amounts
        drive(4'd5, 1'b0, 16'h8001, 16'hFFF1, 8'h00, 16'h0, "R5");
        drive(4'd5, 1'b1, 16'h8001, 16'h0001, 8'h00, 16'h0, "R5");
        drive(4'd5, 1'b0, 16'h1234, 16'h0010, 8'h00, 16'h0, "R5");
        drive(4'd5, 1'b0, 16'h1234, 16'h000F, 8'h00, 16'h0, "R5");
        // R6 loads with push
        drive(4'd8, 1'b0, 16'hBEEF, 16'h0, 8'h7E, 16'h0, "R6");
        drive(4'd9, 1'b0, 16'h0000, 16'h0, 8'h80, 16'h0, "R6");
        drive(4'd9, 1'b0, 16'hFFFF, 16'h0, 8'h7F, 16'h0, "R6");
        // R7 and R8: back-to-back lossy ops, new value differs from old
        drive(4'd10, 1'b0, 16'h8000, 16'h0003, 8'h00, 16'h0, "R7");
        drive(4'd10, 1'b0, 16'h4000, 16'hFF0E, 8'h00, 16'h0, "R7");
        drive(4'd11, 1'b0, 16'h00F0, 16'h0F00, 8'h00, 16'h0, "R8");
        drive(4'd12, 1'b0, 16'hFF00, 16'h0FF0, 8'h00, 16'h0, "R8");
        drive(4'd13, 1'b0, 16'h1111, 16'h2222, 8'h00, 16'h0, "R8");
        // R9 reverse lossy restores from the stack top
        drive(4'd8, 1'b1, 16'h7E00, 16'h0, 8'h7E, 16'hBEEF, "R9");
        drive(4'd11, 1'b1, 16'h0FF0, 16'h0F00, 8'h00, 16'h00F0, "R9");
        drive(4'd13, 1'b1, 16'h2222, 16'h2222, 8'h00, 16'hCAFE, "R9");
        // R10 invertible ops leave the stack alone in reverse
        drive(4'd1, 1'b1, 16'h0000, 16'h0, 8'h55, 16'hDEAD, "R10");
        drive(4'd5, 1'b1, 16'h0001, 16'h0004, 8'h00, 16'hDEAD, "R10");
        idle(2);
        // R11 unassigned codes
        drive(4'd6, 1'b0, 16'h1, 16'h1, 8'h1, 16'h1, "R11");
        drive(4'd7, 1'b1, 16'h1, 16'h1, 8'h1, 16'h1, "R11");
        drive(4'd14, 1'b0, 16'h1, 16'h1, 8'h1, 16'h1, "R11");
        drive(4'd15, 1'b1, 16'h1, 16'h1, 8'h1, 16'h1, "R11");
        idle(1);
        // R12 round trips through the design
        for (int op = 0; op < 14; op++) begin
            if (op != 6 && op != 7) roundtrip(4'(op), 16'h9A5C, 16'h0007, 8'hC3);
        end
        idle(4);
        compared++;
        if (sbq.size() != 0) begin
            mismatched++;
            $display("FAIL R2 queue left actual=%0d expected=0", sbq.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule